// File: doc/BRIEF.md
# SIMD Lane Rounding Right Shifter

This block takes a vector operand of 64 or 128 bits and cuts it into equal lanes of 8, 16, 32 or 64 bits. It shifts every lane right by one shared immediate amount and rounds each result to nearest. Rounding works by adding half the weight of the lowest kept bit before the shift. The sum is formed one bit wider than the lane, so a carry that leaves the lane is not lost. Only the low lane-width bits of the shifted sum are returned.

Lane width, signed or unsigned interpretation and operand width are all chosen per operation at run time. The block sits in a vector execution pipe. A parameter selects either a purely combinational result or one register stage with a valid strobe that travels beside the data, giving a fixed latency of one cycle. The pipe cannot stall this block.

Top module: `rshr_vec`

## Requirements
- R1: With `is_signed`=0 and 1 <= `shamt` < esize, each lane result equals floor((x + 2^(shamt-1)) / 2^shamt) taken modulo 2^esize, where x is the lane read as an unsigned integer.
- R2: With `is_signed`=1 and 1 <= `shamt` < esize, each lane is read as two's complement, and the result is floor((x + 2^(shamt-1)) / 2^shamt) written back as esize-bit two's complement. The floor is toward minus infinity.
- R3: The rounding sum is formed with one guard bit above the lane. For an unsigned lane of all ones and `shamt`=1, the result is 2^(esize-1) and not zero.
- R4: `lane_sz` encodes esize as 0=8, 1=16, 2=32, 3=64 bits. Lane i occupies bits [i*esize +: esize] of both operand and result. No lane affects another lane.
- R5: When `shamt` >= esize, every processed lane returns zero.
- R6: When `shamt` = 0, every processed lane returns its input element unchanged.
- R7: With `wide`=0, only bits [63:0] are processed. Bits [127:64] of the result are zero whatever the upper operand bits hold.
- R8: With `wide`=1, all 128 operand bits are processed, as 128/esize lanes.
- R9: With REG_OUT=1, `out_valid` equals `in_valid` delayed by one clock, and `out_vec` carries the result of the operation accepted on that earlier clock. Both outputs are zero after reset.
- R10: With REG_OUT=1, `out_vec` keeps its value on every clock where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_vec | input | 128 | Vector operand |
| lane_sz | input | 2 | Lane size code (0=8, 1=16, 2=32, 3=64 bits) |
| is_signed | input | 1 | 1 = two's complement lanes, 0 = unsigned lanes |
| wide | input | 1 | 1 = 128-bit operand, 0 = 64-bit operand |
| shamt | input | 7 | Right shift amount, an unsigned integer |
| out_valid | output | 1 | Result present on out_vec |
| out_vec | output | 128 | Rounded, shifted vector |

## Verification
The rounding increment and the lane partitioning meet in the same cycle whenever the rounding add overflows a lane. If the guard bit were missing, or a lane's adder were chained to its neighbour, that carry would be lost or would land in the next lane. The bench provokes this by sending all-ones operands with a shift of one at every lane size, in both sign modes, and back to back. It judges every lane against the floor-of-quotient formula, computed at 66-bit precision in the bench and compared field by field, with hand-computed vectors for the all-ones and extreme signed values.

// File: rtl/rshr_pkg.sv
package rshr_pkg;

   localparam int unsigned NUM_SIZES = 4;
   localparam int unsigned MIN_LANE  = 8;

   typedef enum logic [1:0] {
      LS_8  = 2'd0,
      LS_16 = 2'd1,
      LS_32 = 2'd2,
      LS_64 = 2'd3
   } lane_sz_e;

   function automatic int lane_bits(lane_sz_e sz);
      return int'(MIN_LANE) << int'(sz);
   endfunction

endpackage

// File: rtl/rshr_lane.sv
module rshr_lane #(
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned SHIFT_W = 7
) (
   input  logic [LANE_W-1:0]  elem_i,
   input  logic               sgn_i,
   input  logic [SHIFT_W-1:0] sh_i,
   output logic [LANE_W-1:0]  res_o
);

   localparam int unsigned EXT_W = LANE_W + 1;
   localparam logic [SHIFT_W-1:0] LIM = SHIFT_W'(LANE_W);

   generate
      if (LANE_W < 2) begin : g_bad_lane
         $error("rshr_lane: LANE_W must be at least 2");
      end
      if (LANE_W >= (1 << SHIFT_W)) begin : g_bad_shift
         $error("rshr_lane: SHIFT_W too narrow to express LANE_W");
      end
   endgenerate

   logic [EXT_W-1:0] ext;
   logic [EXT_W-1:0] half;
   logic [EXT_W-1:0] sum;
   logic [EXT_W-1:0] shifted;
   logic             lane_unused_msb;

   always_comb begin
      ext  = {sgn_i & elem_i[LANE_W-1], elem_i};
      half = (sh_i == '0) ? '0 : (EXT_W'(1) << (sh_i - SHIFT_W'(1)));
      sum  = ext + half;
      if (sgn_i) begin
         shifted = $unsigned($signed(sum) >>> sh_i);
      end else begin
         shifted = sum >> sh_i;
      end
   end

   assign lane_unused_msb = shifted[LANE_W];

   always_comb begin
      if (sh_i >= LIM) begin
         res_o = '0;
      end else if (sh_i == '0) begin
         res_o = elem_i;
      end else begin
         res_o = shifted[LANE_W-1:0];
      end
   end

endmodule

// File: rtl/rshr_group.sv
module rshr_group #(
   parameter int unsigned VEC_W   = 128,
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned SHIFT_W = 7
) (
   input  logic [VEC_W-1:0]   vec_i,
   input  logic               sgn_i,
   input  logic [SHIFT_W-1:0] sh_i,
   output logic [VEC_W-1:0]   res_o
);

   localparam int unsigned N_LANES = VEC_W / LANE_W;

   generate
      if ((VEC_W % LANE_W) != 0) begin : g_bad_div
         $error("rshr_group: VEC_W must be a multiple of LANE_W");
      end
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         rshr_lane #(
            .LANE_W  (LANE_W),
            .SHIFT_W (SHIFT_W)
         ) u_lane (
            .elem_i (vec_i[i*LANE_W +: LANE_W]),
            .sgn_i  (sgn_i),
            .sh_i   (sh_i),
            .res_o  (res_o[i*LANE_W +: LANE_W])
         );
      end
   endgenerate

endmodule

// File: rtl/rshr_vec.sv
module rshr_vec #(
   parameter int unsigned VEC_W   = 128,
   parameter int unsigned SHIFT_W = 7,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [VEC_W-1:0]   in_vec,
   input  logic [1:0]         lane_sz,
   input  logic               is_signed,
   input  logic               wide,
   input  logic [SHIFT_W-1:0] shamt,
   output logic               out_valid,
   output logic [VEC_W-1:0]   out_vec
);

   import rshr_pkg::*;

   localparam int unsigned HALF_W = VEC_W / 2;

   generate
      if (VEC_W != 128) begin : g_bad_vec
         $error("rshr_vec: VEC_W must be 128 (two 64-bit halves)");
      end
      if (SHIFT_W < 7) begin : g_bad_shw
         $error("rshr_vec: SHIFT_W must hold the value 64");
      end
   endgenerate

   lane_sz_e         sz_e;
   logic [VEC_W-1:0] grp_res [NUM_SIZES];
   logic [VEC_W-1:0] sel_res;
   logic [VEC_W-1:0] res_comb;

   assign sz_e = lane_sz_e'(lane_sz);

   generate
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
         rshr_group #(
            .VEC_W   (VEC_W),
            .LANE_W  (MIN_LANE << g),
            .SHIFT_W (SHIFT_W)
         ) u_grp (
            .vec_i (in_vec),
            .sgn_i (is_signed),
            .sh_i  (shamt),
            .res_o (grp_res[g])
         );
      end
   endgenerate

   always_comb begin
      sel_res = grp_res[sz_e];
      if (wide) begin
         res_comb = sel_res;
      end else begin
         res_comb = {HALF_W'(0), sel_res[HALF_W-1:0]};
      end
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_vec   <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_vec <= res_comb;
               end
            end
         end

         p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
         p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_vec == $past(res_comb)));
         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_vec));
         p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !wide) |=> (out_vec[VEC_W-1:HALF_W] == '0));
         p_big_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (int'(shamt) >= lane_bits(sz_e))) |=> (out_vec == '0));
         p_zero_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && wide && (shamt == '0)) |=> (out_vec == $past(in_vec)));
      end else begin : g_comb
         logic comb_unused_clk;
         assign comb_unused_clk = clk ^ rst_n;
         assign out_valid = in_valid;
         assign out_vec   = res_comb;
      end
   endgenerate

endmodule

// File: tb/rshr_vec_test.sv
module rshr_vec_test;

   typedef struct {
      logic [127:0] exp;
      string        tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_vec = '0;
   logic [1:0]   lane_sz = '0;
   logic         is_signed = 1'b0;
   logic         wide = 1'b0;
   logic [6:0]   shamt = '0;
   logic         out_valid;
   logic [127:0] out_vec;

   int           n_checks = 0;
   int           n_fail = 0;
   item_t        sb[$];
   logic [127:0] last_exp = '0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   rshr_vec uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_vec    (in_vec),
      .lane_sz   (lane_sz),
      .is_signed (is_signed),
      .wide      (wide),
      .shamt     (shamt),
      .out_valid (out_valid),
      .out_vec   (out_vec)
   );

   function automatic logic [127:0] model(logic [127:0] v, int sz, bit sg, bit wd, int sh);
      int           eb;
      int           n;
      logic [65:0]  mask;
      logic [65:0]  x;
      logic [65:0]  sum;
      logic [65:0]  r;
      logic [127:0] res;
      eb   = 8 << sz;
      n    = (wd ? 128 : 64) / eb;
      mask = (66'(1) << eb) - 66'(1);
      res  = '0;
      for (int i = 0; i < n; i++) begin
         x = 66'(v >> (i * eb)) & mask;
         if (sg && x[eb-1]) x = x | ~mask;
         if (sh == 0) begin
            r = x;
         end else if (sh >= eb) begin
            r = '0;
         end else begin
            sum = x + (66'(1) << (sh - 1));
            if (sg) r = $unsigned($signed(sum) >>> sh);
            else    r = sum >> sh;
         end
         res = res | (128'(r & mask) << (i * eb));
      end
      return res;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send_exp(logic [127:0] v, int sz, bit sg, bit wd, int sh,
                           logic [127:0] exp, string tag);
      item_t it;
      @(posedge clk);
      #2;
      in_valid  = 1'b1;
      in_vec    = v;
      lane_sz   = 2'(sz);
      is_signed = sg;
      wide      = wd;
      shamt     = 7'(sh);
      it.exp = exp;
      it.tag = tag;
      sb.push_back(it);
      last_exp = exp;
   endtask

   task automatic send(logic [127:0] v, int sz, bit sg, bit wd, int sh, string tag);
      send_exp(v, sz, sg, wd, sh, model(v, sz, sg, wd, sh), tag);
   endtask

   task automatic idle(int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(posedge clk);
         #2;
         in_valid = 1'b0;
         in_vec   = {4{32'hDEAD_BEEF}};
         shamt    = 7'd3;
      end
   endtask

   // Monitor: pops the scoreboard whenever the design presents a result.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            check("R9 unexpected out_valid", {127'b0, out_valid}, 128'b0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, out_vec, it.exp);
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   logic [127:0] seed = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset out_valid", {127'b0, out_valid}, 128'b0);
      check("R9 reset out_vec", out_vec, 128'b0);
      @(posedge clk);
      #2 rst_n = 1'b1;

      // R3 carry kept: all ones, shift 1, every lane size, hand values
      send_exp({128{1'b1}}, 0, 0, 1, 1, {16{8'h80}}, "R3 8b");
      send_exp({128{1'b1}}, 1, 0, 1, 1, {8{16'h8000}}, "R3 16b");
      send_exp({128{1'b1}}, 2, 0, 1, 1, {4{32'h8000_0000}}, "R3 32b");
      send_exp({128{1'b1}}, 3, 0, 1, 1, {2{64'h8000_0000_0000_0000}}, "R3 64b");
      // R2 signed extremes: 0x7F, 0x80, 0xFF, 0x01 with shift 1
      send_exp(128'h01FF_807F, 0, 1, 1, 1, 128'h0100_C040, "R2 8b extremes");
      // R2 signed all ones with shift 1 rounds to zero
      send_exp({128{1'b1}}, 0, 1, 1, 1, 128'b0, "R2 minus one");
      // R2 most negative 64-bit, shift 63 -> -1
      send_exp({64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, 3, 1, 1, 63,
               {64'hFFFF_FFFF_FFFF_FFFF, 64'h1}, "R2 64b extremes");
      // R1 unsigned 0xFF with shift 7 -> 2
      send_exp({16{8'hFF}}, 0, 0, 1, 7, {16{8'h02}}, "R1 8b shift7");
      idle(2);

      // R5 shift equal to and above lane size
      send_exp({128{1'b1}}, 0, 1, 1, 8, 128'b0, "R5 8b shift8");
      send_exp({128{1'b1}}, 1, 0, 1, 16, 128'b0, "R5 16b shift16");
      send_exp({128{1'b1}}, 2, 1, 1, 32, 128'b0, "R5 32b shift32");
      send_exp({128{1'b1}}, 3, 0, 1, 64, 128'b0, "R5 64b shift64");
      send_exp({128{1'b1}}, 3, 1, 1, 127, 128'b0, "R5 shift127");
      // R6 shift zero copies
      send_exp(seed, 1, 1, 1, 0, seed, "R6 copy wide");
      send_exp(seed, 2, 0, 0, 0, {64'b0, seed[63:0]}, "R6 copy narrow");
      // R7 narrow: upper half ignored and zero
      send_exp({64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF}, 0, 0, 0, 1,
               {64'b0, 64'h0000_0000_0000_0080}, "R7 narrow upper");
      send(seed, 3, 1, 0, 5, "R7 narrow 64b");
      // R8 wide, R4 lane independence
      send(seed, 1, 0, 1, 4, "R8 R4 16b");
      send(seed, 2, 1, 1, 9, "R8 R4 32b");
      send({8'h7F, 8'h80, 8'h00, 8'hFF, 96'h0}, 0, 1, 1, 3, "R4 lanes top");
      idle(4);

      // R10 hold while idle
      @(negedge clk);
      check("R10 hold out_vec", out_vec, last_exp);
      check("R9 idle out_valid", {127'b0, out_valid}, 128'b0);

      // Mixed stream, back to back (R9), R1 and R2 formulas
      for (int k = 0; k < 64; k++) begin
         seed = {seed[126:0], 1'b0} ^ (seed[127] ? 128'h87 : 128'h0) ^ 128'(k * 32'h9E37_79B9);
         if (k % 3 == 0) begin
            send(seed, k % 4, k[2], k[3], (k * 7) % 70, k[2] ? "R2 stream" : "R1 stream");
         end else begin
            send(seed, (k / 4) % 4, k[0], 1'b1, 1 + (k % 20), k[0] ? "R2 stream" : "R1 stream");
         end
         if (k % 9 == 8) idle(1);
      end
      idle(3);

      @(negedge clk);
      check("R10 hold after stream", out_vec, last_exp);
      check("R9 scoreboard drained", 128'(sb.size()), 128'b0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule